// File: doc/BRIEF.md
# Bit-Addressable Scratchpad RAM with Carry Processor

This block is a 128-byte internal scratchpad that can be reached in two ways at once. One way is a byte port with one address, write data, write enable and read data. The other is a single-bit operation port. In the single-bit view, a window of sixteen bytes starting at byte 20h is split into 128 individually addressable bits. A one-bit carry register acts as the accumulator for boolean work on those bits. Each bit operation can clear, set, complement, copy into or out of the carry, combine the carry with the bit or with its inverse, read the bit, or test the bit and clear it.

A bit that is modified is updated by reading the whole byte, changing one position and writing the byte back one cycle later. A two-state controller handles this sequence. It waits in `ST_IDLE`. A bit request that writes goes to `ST_WRITEBACK` (transition "accept-write"). The controller always returns to `ST_IDLE` on the next edge (transition "commit"). Requests that do not write stay in `ST_IDLE` (transition "accept-nowrite"). While the controller is in `ST_WRITEBACK`, `busy` is high and both ports ignore new writes and new bit requests.

Top module: `sbr_bitram`

## Requirements
- R1: The byte port stores 128 bytes at addresses 00h–7Fh. `byte_rdata` shows the byte at `byte_addr` combinationally. A write with `byte_we` high while `busy` is low takes effect at the clock edge.
- R2: A bit address b below 80h selects byte 20h + b[6:3] and bit position b[2:0] within that byte. The effect is visible through the byte port.
- R3: Op codes 3 (clear bit), 4 (set bit) and 5 (complement bit) change only the addressed bit. `busy` is high for exactly the one cycle after the request. The new byte is readable once `busy` falls.
- R4: Op codes 0 (clear carry), 1 (set carry) and 2 (complement carry) update `carry` at the accepting edge. Reset clears `carry` and `busy`.
- R5: Op code 6 copies the addressed bit into `carry`. Op code 7 writes `carry` into the addressed bit.
- R6: Op codes 8 (carry AND bit), 9 (carry AND NOT bit), 10 (carry OR bit) and 11 (carry OR NOT bit) update only `carry`. They leave the byte unchanged and do not raise `busy`.
- R7: Op code 12 returns the old bit on `bit_result` and leaves the bit cleared.
- R8: A bit-using op (codes 3–13) with a bit address of 80h or more raises `bit_invalid` and returns 0. It changes neither RAM nor `carry`, and it does not raise `busy`.
- R9: While `busy` is high, a byte write and a bit request are both ignored.
- R10: A byte write and a bit op that hit the same byte in the same cycle are ordered with the byte write first. The bit op modifies the newly written value.
- R11: `bit_result` and `bit_invalid` are registered and valid in the cycle after an accepted request. Op code 13 returns the bit with no change and no `busy`. Codes 14 and 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_addr | input | 7 | Byte port address |
| byte_we | input | 1 | Byte write enable |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data (combinational) |
| busy | output | 1 | Write-back in progress; new writes and bit requests ignored |
| bit_req | input | 1 | Bit operation request |
| bit_op | input | 4 | Bit operation code |
| bit_addr | input | 8 | Bit address |
| bit_result | output | 1 | Old value of the addressed bit |
| bit_invalid | output | 1 | Bit address out of range |
| carry | output | 1 | Carry flag |

## Verification
The bench targets the two ends of the bit window, bit 00h and bit 7Fh. A wrong byte or position mapping at either end would corrupt a neighbouring byte. It checks the inverted AND and OR forms with both bit values, which exposes a missing inversion. It also runs test-and-clear on a set bit and then on a clear bit. A byte write and a bit set aimed at the same byte in one cycle expose a design that merges into stale data, because the byte write would then be lost. Writes issued during `busy`, and bit addresses of 80h and above, expose a design that lets them corrupt RAM or carry.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [3:0] {
        OP_CLR_C  = 4'd0,
        OP_SET_C  = 4'd1,
        OP_CPL_C  = 4'd2,
        OP_CLR_B  = 4'd3,
        OP_SET_B  = 4'd4,
        OP_CPL_B  = 4'd5,
        OP_B2C    = 4'd6,
        OP_C2B    = 4'd7,
        OP_AND    = 4'd8,
        OP_ANDN   = 4'd9,
        OP_OR     = 4'd10,
        OP_ORN    = 4'd11,
        OP_TSTCLR = 4'd12,
        OP_RD_B   = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } bit_op_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_WRITEBACK = 1'b1
    } ctrl_state_e;

    function automatic logic op_uses_bit(bit_op_e op);
        return (op >= OP_CLR_B) && (op <= OP_RD_B);
    endfunction

endpackage

// File: rtl/sbr_storage.sv
module sbr_storage #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sbr_bit_alu.sv
module sbr_bit_alu
    import sbr_pkg::*;
(
    input  bit_op_e op,
    input  logic    old_bit,
    input  logic    carry_in,
    output logic    new_bit,
    output logic    new_carry,
    output logic    wr_bit
);
    always_comb begin
        new_bit   = old_bit;
        new_carry = carry_in;
        wr_bit    = 1'b0;
        unique case (op)
            OP_CLR_C:  new_carry = 1'b0;
            OP_SET_C:  new_carry = 1'b1;
            OP_CPL_C:  new_carry = ~carry_in;
            OP_CLR_B:  begin new_bit = 1'b0;      wr_bit = 1'b1; end
            OP_SET_B:  begin new_bit = 1'b1;      wr_bit = 1'b1; end
            OP_CPL_B:  begin new_bit = ~old_bit;  wr_bit = 1'b1; end
            OP_B2C:    new_carry = old_bit;
            OP_C2B:    begin new_bit = carry_in;  wr_bit = 1'b1; end
            OP_AND:    new_carry = carry_in & old_bit;
            OP_ANDN:   new_carry = carry_in & ~old_bit;
            OP_OR:     new_carry = carry_in | old_bit;
            OP_ORN:    new_carry = carry_in | ~old_bit;
            OP_TSTCLR: begin new_bit = 1'b0;      wr_bit = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
    import sbr_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int DATA_W     = 8,
    parameter int BIT_BASE   = 32,
    parameter int BIT_BYTES  = 16,
    parameter int BIT_ADDR_W = 8,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int POS_W     = $clog2(DATA_W),
    localparam int SEL_W     = $clog2(BIT_BYTES),
    localparam int BIT_SPACE = BIT_BYTES * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_req,
    input  logic [3:0]            bit_op,
    input  logic [BIT_ADDR_W-1:0] bit_addr,
    input  logic                  byte_we,
    input  logic [ADDR_W-1:0]     byte_addr,
    input  logic [DATA_W-1:0]     byte_wdata,
    input  logic [DATA_W-1:0]     mem_rd,
    output logic [ADDR_W-1:0]     tgt_addr,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  busy,
    output logic                  carry,
    output logic                  bit_result,
    output logic                  bit_invalid
);
    ctrl_state_e state, state_nx;
    bit_op_e     op;
    logic [POS_W-1:0]  bit_pos;
    logic [SEL_W-1:0]  byte_off;
    logic [DATA_W-1:0] src_byte, merged, pend_data;
    logic [ADDR_W-1:0] pend_addr;
    logic addr_ok, uses, bit_go, byte_wr_go, old_bit;
    logic new_bit, new_carry, wr_bit, start_wb;

    assign op         = bit_op_e'(bit_op);
    assign addr_ok    = {1'b0, bit_addr} < (BIT_ADDR_W+1)'(BIT_SPACE);
    assign uses       = op_uses_bit(op);
    assign bit_pos    = bit_addr[POS_W-1:0];
    assign byte_off   = bit_addr[POS_W +: SEL_W];
    assign tgt_addr   = ADDR_W'(BIT_BASE) + ADDR_W'(byte_off);
    assign busy       = (state == ST_WRITEBACK);
    assign bit_go     = bit_req && !busy;
    assign byte_wr_go = byte_we && !busy;

    // Same-cycle byte write is ordered ahead of the bit op
    assign src_byte = (byte_wr_go && byte_addr == tgt_addr) ? byte_wdata : mem_rd;
    assign old_bit  = addr_ok ? src_byte[bit_pos] : 1'b0;

    sbr_bit_alu u_alu (
        .op        (op),
        .old_bit   (old_bit),
        .carry_in  (carry),
        .new_bit   (new_bit),
        .new_carry (new_carry),
        .wr_bit    (wr_bit)
    );

    always_comb begin
        merged          = src_byte;
        merged[bit_pos] = new_bit;
    end

    assign start_wb = bit_go && wr_bit && addr_ok;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_wb) state_nx = ST_WRITEBACK;
            ST_WRITEBACK: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry       <= 1'b0;
            bit_result  <= 1'b0;
            bit_invalid <= 1'b0;
            pend_addr   <= '0;
            pend_data   <= '0;
        end else if (bit_go) begin
            bit_invalid <= uses && !addr_ok;
            bit_result  <= uses && addr_ok && old_bit;
            if (!uses || addr_ok) carry <= new_carry;
            if (start_wb) begin
                pend_addr <= tgt_addr;
                pend_data <= merged;
            end
        end
    end

    assign wr_en   = busy || byte_wr_go;
    assign wr_addr = busy ? pend_addr : byte_addr;
    assign wr_data = busy ? pend_data : byte_wdata;

    assert_wb_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    assert_b2c_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && op == OP_B2C && addr_ok) |=> (carry == $past(old_bit)));
    assert_logic_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && op >= OP_AND && op <= OP_ORN) |=> !busy);
    assert_invalid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && uses && !addr_ok) |=> (!busy && bit_invalid && !bit_result && carry == $past(carry)));
    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_req) |=> $stable(carry));
endmodule

// File: rtl/sbr_bitram.sv
module sbr_bitram #(
    parameter int DEPTH      = 128,
    parameter int DATA_W     = 8,
    parameter int BIT_BASE   = 32,
    parameter int BIT_BYTES  = 16,
    parameter int BIT_ADDR_W = 8,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     byte_addr,
    input  logic                  byte_we,
    input  logic [DATA_W-1:0]     byte_wdata,
    output logic [DATA_W-1:0]     byte_rdata,
    output logic                  busy,
    input  logic                  bit_req,
    input  logic [3:0]            bit_op,
    input  logic [BIT_ADDR_W-1:0] bit_addr,
    output logic                  bit_result,
    output logic                  bit_invalid,
    output logic                  carry
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, tgt_addr;
    logic [DATA_W-1:0] wr_data, tgt_byte;

    sbr_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (byte_addr),
        .rdata_a (byte_rdata),
        .raddr_b (tgt_addr),
        .rdata_b (tgt_byte)
    );

    sbr_ctrl #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE),
        .BIT_BYTES(BIT_BYTES), .BIT_ADDR_W(BIT_ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_req     (bit_req),
        .bit_op      (bit_op),
        .bit_addr    (bit_addr),
        .byte_we     (byte_we),
        .byte_addr   (byte_addr),
        .byte_wdata  (byte_wdata),
        .mem_rd      (tgt_byte),
        .tgt_addr    (tgt_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .carry       (carry),
        .bit_result  (bit_result),
        .bit_invalid (bit_invalid)
    );
endmodule

// File: tb/tb_sbr_bitram.sv
module tb_sbr_bitram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] byte_addr = '0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_wdata = '0;
    logic [7:0] byte_rdata;
    logic       busy;
    logic       bit_req = 1'b0;
    logic [3:0] bit_op = '0;
    logic [7:0] bit_addr = '0;
    logic       bit_result, bit_invalid, carry;

    int total = 0;
    int bad = 0;
    logic [7:0] model [128];
    logic m_carry = 1'b0;

    always #5 clk = ~clk;

    sbr_bitram dut (
        .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .byte_we(byte_we),
        .byte_wdata(byte_wdata), .byte_rdata(byte_rdata), .busy(busy),
        .bit_req(bit_req), .bit_op(bit_op), .bit_addr(bit_addr),
        .bit_result(bit_result), .bit_invalid(bit_invalid), .carry(carry)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        byte_we = 1'b1; byte_addr = a; byte_wdata = d;
        model[a] = d;
        @(negedge clk);
        byte_we = 1'b0;
    endtask

    task automatic rd_byte(input logic [6:0] a, input string req);
        @(negedge clk);
        byte_addr = a;
        #1 chk(req, {24'd0, byte_rdata}, {24'd0, model[a]});
    endtask

    // Runs one op; checks result, invalid, carry, busy and the byte afterwards
    task automatic do_bit(input logic [3:0] op, input logic [7:0] a, input string req);
        logic ok, uses, ob, nb, nc, wr;
        logic [6:0] idx;
        logic [2:0] pos;
        ok   = a < 8'h80;
        idx  = 7'h20 + {3'd0, a[6:3]};
        pos  = a[2:0];
        ob   = ok ? model[idx][pos] : 1'b0;
        uses = (op >= 4'd3) && (op <= 4'd13);
        nb = ob; nc = m_carry; wr = 1'b0;
        case (op)
            4'd0:  nc = 1'b0;
            4'd1:  nc = 1'b1;
            4'd2:  nc = ~m_carry;
            4'd3:  begin nb = 1'b0; wr = 1'b1; end
            4'd4:  begin nb = 1'b1; wr = 1'b1; end
            4'd5:  begin nb = ~ob; wr = 1'b1; end
            4'd6:  nc = ob;
            4'd7:  begin nb = m_carry; wr = 1'b1; end
            4'd8:  nc = m_carry & ob;
            4'd9:  nc = m_carry & ~ob;
            4'd10: nc = m_carry | ob;
            4'd11: nc = m_carry | ~ob;
            4'd12: begin nb = 1'b0; wr = 1'b1; end
            default: ;
        endcase
        if (!uses || ok) m_carry = nc;
        if (wr && ok) model[idx][pos] = nb;
        @(negedge clk);
        bit_req = 1'b1; bit_op = op; bit_addr = a;
        @(posedge clk);
        #1;
        chk({req, " result"},  {31'd0, bit_result},  {31'd0, uses && ok && ob});
        chk({req, " invalid"}, {31'd0, bit_invalid}, {31'd0, uses && !ok});
        chk({req, " carry"},   {31'd0, carry},       {31'd0, m_carry});
        chk({req, " busy"},    {31'd0, busy},        {31'd0, wr && ok});
        @(negedge clk);
        bit_req = 1'b0;
        if (ok) rd_byte(idx, {req, " byte"});
    endtask

    task automatic t_reset();
        chk("R4 reset carry", {31'd0, carry}, 32'd0);
        chk("R4 reset busy", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_bytes();
        for (int i = 0; i < 128; i++) wr_byte(7'(i), 8'(i * 37 + 5));
        rd_byte(7'h00, "R1 byte 00");
        rd_byte(7'h2F, "R1 byte 2F");
        rd_byte(7'h7F, "R1 byte 7F");
        wr_byte(7'h20, 8'h00);
        wr_byte(7'h2F, 8'h00);
        rd_byte(7'h20, "R1 overwrite");
    endtask

    task automatic t_carry();
        do_bit(4'd1, 8'h00, "R4 set carry");
        do_bit(4'd2, 8'h00, "R4 cpl carry");
        do_bit(4'd2, 8'h00, "R4 cpl carry again");
        do_bit(4'd0, 8'h00, "R4 clr carry");
    endtask

    task automatic t_bit_rw();
        do_bit(4'd4, 8'h00, "R2 set bit 00");
        do_bit(4'd4, 8'h7F, "R2 set bit 7F");
        do_bit(4'd4, 8'h1B, "R3 set bit 1B");
        do_bit(4'd3, 8'h00, "R3 clr bit 00");
        do_bit(4'd5, 8'h33, "R3 cpl bit 33");
        do_bit(4'd5, 8'h33, "R3 cpl bit 33 back");
        rd_byte(7'h21, "R2 neighbour byte");
    endtask

    task automatic t_moves();
        do_bit(4'd6, 8'h7F, "R5 bit to carry 1");
        do_bit(4'd7, 8'h41, "R5 carry to bit");
        do_bit(4'd6, 8'h00, "R5 bit to carry 0");
        do_bit(4'd7, 8'h41, "R5 carry 0 to bit");
    endtask

    task automatic t_logic();
        do_bit(4'd1, 8'h00, "R6 prep carry");
        do_bit(4'd8, 8'h7F, "R6 and bit 1");
        do_bit(4'd9, 8'h7F, "R6 andn bit 1");
        do_bit(4'd10, 8'h00, "R6 or bit 0");
        do_bit(4'd11, 8'h00, "R6 orn bit 0");
        do_bit(4'd11, 8'h7F, "R6 orn bit 1");
        do_bit(4'd9, 8'h00, "R6 andn bit 0");
    endtask

    task automatic t_tstclr();
        do_bit(4'd4, 8'h52, "R7 prep");
        do_bit(4'd12, 8'h52, "R7 test set");
        do_bit(4'd12, 8'h52, "R7 test clear");
    endtask

    task automatic t_invalid();
        do_bit(4'd1, 8'h00, "R8 prep carry");
        do_bit(4'd3, 8'h80, "R8 clr at 80");
        do_bit(4'd8, 8'hFF, "R8 and at FF");
        rd_byte(7'h20, "R8 byte 20 kept");
        rd_byte(7'h2F, "R8 byte 2F kept");
    endtask

    task automatic t_busy();
        wr_byte(7'h21, 8'h00);
        @(negedge clk);
        bit_req = 1'b1; bit_op = 4'd4; bit_addr = 8'h08;
        model[7'h21][0] = 1'b1;
        @(posedge clk);
        #1 chk("R9 busy up", {31'd0, busy}, 32'd1);
        @(negedge clk);
        bit_op = 4'd2; bit_addr = 8'h09;
        byte_we = 1'b1; byte_addr = 7'h21; byte_wdata = 8'hFF;
        @(posedge clk);
        #1 chk("R9 carry kept", {31'd0, carry}, {31'd0, m_carry});
        chk("R9 busy down", {31'd0, busy}, 32'd0);
        @(negedge clk);
        bit_req = 1'b0; byte_we = 1'b0;
        rd_byte(7'h21, "R9 ignored write");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        byte_we = 1'b1; byte_addr = 7'h25; byte_wdata = 8'hA0;
        bit_req = 1'b1; bit_op = 4'd4; bit_addr = 8'h28;
        model[7'h25] = 8'hA1;
        @(posedge clk);
        #1 chk("R10 busy", {31'd0, busy}, 32'd1);
        @(negedge clk);
        byte_we = 1'b0; bit_req = 1'b0;
        rd_byte(7'h25, "R10 merged byte");
    endtask

    task automatic t_read();
        do_bit(4'd13, 8'h7F, "R11 read bit 1");
        do_bit(4'd13, 8'h00, "R11 read bit 0");
        do_bit(4'd14, 8'h05, "R11 reserved 14");
        do_bit(4'd15, 8'h05, "R11 reserved 15");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 t_reset();
        t_bytes();
        t_carry();
        t_bit_rw();
        t_moves();
        t_logic();
        t_tstclr();
        t_invalid();
        t_busy();
        t_same_cycle();
        t_read();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule